// File: doc/BRIEF.md
# Mixed-Width True Dual-Port RAM

This block is an 18,432-bit synchronous memory with two independent access ports, A and B. Each port has its own clock, enable, write enable, address, write data and registered read data. The width of each port is set at elaboration to 1, 2, 4, 9, 18 or 36 bits, and the two widths may differ. Both ports see one shared array, so a word written through one port can be read back through the other at its own width. This supports plain read/write on either side and transfers in both directions, for example a 9-bit producer feeding an 18-bit consumer.

Ports of 9, 18 or 36 bits carry one parity bit for each data byte. The parity bits are stored next to the data. Ports of 4 bits or narrower address only the 16,384 data bits. A parameter turns port B off and leaves a single-port memory. A second parameter limits each port to at most 18 bits, for use where the upper data lines are reserved for another function.

Top module: `mwdp_ram`

## Requirements
- R1: A port whose width W holds D data bits has 16384/D words and an address of 14-log2(D) bits. D is W for W of 4 or less, and 8·W/9 otherwise. Its highest address reaches the last bits of the array.
- R2: Reads and writes take effect on the rising edge of the port's own clock while the port is enabled. On a write, the read data register shows the word just written (write-first). On a read, it shows the stored word one edge later.
- R3: While a port's enable is low, its read data register keeps its value and its write enable has no effect.
- R4: Data bit k of the shared array is bit k mod D of word floor(k/D) on a port with D data bits. So word j of a port twice as wide holds words 2j (low half) and 2j+1 (high half) of the narrower port. Parity bit m follows the same rule with P parity bits per word.
- R5: On a port with P = W/9 parity bits, the port word is {parity[P-1:0], data[D-1:0]}. Parity bit i belongs to data byte i.
- R6: A port of 4 bits or narrower neither reads nor changes parity bits. Parity written by a wide port survives narrow writes to the same bytes.
- R7: A word written through either port can be read through the other port, in both directions, when the two widths differ.
- R8: An active-low reset clears both read data registers at once. It does not clear the array contents.
- R9: With SINGLE_PORT set, port B writes are ignored and its read data stays zero. Port A works as in R1 to R7.
- R10: With LIMIT_18 set, a port configured wider than 18 bits becomes an 18-bit port, 1,024 words deep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_n | input | 1 | Active-low asynchronous clear of both read data registers |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| addr_a | input | AWA | Port A word address |
| din_a | input | WA | Port A write word |
| dout_a | output | WA | Port A registered read word |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| addr_b | input | AWB | Port B word address |
| din_b | input | WB | Port B write word |
| dout_b | output | WB | Port B registered read word |

## Verification
Every read and write result appears on the port's read data register exactly one rising edge after the enabled request. The reset clear shows up as soon as reset falls. The bench drives inputs on the falling edge and samples on the next falling edge, which is one registered stage later. It samples the reset state while reset is still low. The expected word comes from a bit-level model of the array that is updated after each cycle. Cycles in which both ports would touch the same bits during a write are detected beforehand: the bench drops port B's request for that cycle and counts these cycles.

// File: rtl/mwdp_ram.sv
module mwdp_ram #(
  parameter int WIDTH_A     = 9,
  parameter int WIDTH_B     = 18,
  parameter bit SINGLE_PORT = 1'b0,
  parameter bit LIMIT_18    = 1'b0,
  localparam int WA  = (LIMIT_18 && WIDTH_A > 18) ? 18 : WIDTH_A,
  localparam int WB  = (LIMIT_18 && WIDTH_B > 18) ? 18 : WIDTH_B,
  localparam int DA  = (WA >= 9) ? (WA / 9) * 8 : WA,
  localparam int DB  = (WB >= 9) ? (WB / 9) * 8 : WB,
  localparam int AWA = 14 - $clog2(DA),
  localparam int AWB = 14 - $clog2(DB)
) (
  input  logic           clk_a,
  input  logic           rst_n,
  input  logic           en_a,
  input  logic           we_a,
  input  logic [AWA-1:0] addr_a,
  input  logic [WA-1:0]  din_a,
  output logic [WA-1:0]  dout_a,
  input  logic           clk_b,
  input  logic           en_b,
  input  logic           we_b,
  input  logic [AWB-1:0] addr_b,
  input  logic [WB-1:0]  din_b,
  output logic [WB-1:0]  dout_b
);
  localparam int ROWS = 512;
  localparam int PA   = (WA >= 9) ? WA / 9 : 0;
  localparam int PB   = (WB >= 9) ? WB / 9 : 0;
  localparam int LBA  = 5 - $clog2(DA);
  localparam int LBB  = 5 - $clog2(DB);

  function automatic logic [35:0] place(input logic [35:0] w, input int d, input int p, input int lane);
    logic [35:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) if (i < d) r[lane*d+i] = w[i];
    for (int i = 0; i < 4; i++)  if (i < p) r[32+lane*p+i] = w[d+i];
    return r;
  endfunction

  function automatic logic [35:0] pick(input logic [35:0] row, input int d, input int p, input int lane);
    logic [35:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) if (i < d) r[i] = row[lane*d+i];
    for (int i = 0; i < 4; i++)  if (i < p) r[d+i] = row[32+lane*p+i];
    return r;
  endfunction

  logic [35:0] bank_a [ROWS];
  logic [35:0] bank_b [ROWS];

  wire [8:0]  row_a  = 9'(addr_a >> LBA);
  wire [8:0]  row_b  = 9'(addr_b >> LBB);
  wire [4:0]  lane_a = 5'(addr_a) & 5'((1 << LBA) - 1);
  wire [4:0]  lane_b = 5'(addr_b) & 5'((1 << LBB) - 1);
  wire [35:0] mask_a = place('1, DA, PA, int'(lane_a));
  wire [35:0] mask_b = place('1, DB, PB, int'(lane_b));
  wire [35:0] wrow_a = place(36'(din_a), DA, PA, int'(lane_a));
  wire [35:0] wrow_b = place(36'(din_b), DB, PB, int'(lane_b));
  wire [35:0] rrow_a = bank_a[row_a] ^ bank_b[row_a];
  wire [35:0] rrow_b = bank_a[row_b] ^ bank_b[row_b];
  wire        wr_b   = en_b && we_b && !SINGLE_PORT;

  always_ff @(posedge clk_a)
    if (en_a && we_a)
      bank_a[row_a] <= (bank_a[row_a] & ~mask_a) | ((wrow_a ^ bank_b[row_a]) & mask_a);

  always_ff @(posedge clk_b)
    if (wr_b)
      bank_b[row_b] <= (bank_b[row_b] & ~mask_b) | ((wrow_b ^ bank_a[row_b]) & mask_b);

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n)    dout_a <= '0;
    else if (en_a) dout_a <= we_a ? din_a : WA'(pick(rrow_a, DA, PA, int'(lane_a)));

  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n)                    dout_b <= '0;
    else if (en_b && !SINGLE_PORT) dout_b <= we_b ? din_b : WB'(pick(rrow_b, DB, PB, int'(lane_b)));
endmodule

// File: rtl/mwdp_ram_chk.sv
module mwdp_ram_chk #(
  parameter int W_A = 9,
  parameter int W_B = 18,
  parameter bit SP  = 1'b0
) (
  input logic           clk_a,
  input logic           clk_b,
  input logic           rst_n,
  input logic           en_a,
  input logic           we_a,
  input logic [W_A-1:0] din_a,
  input logic [W_A-1:0] dout_a,
  input logic           en_b,
  input logic           we_b,
  input logic [W_B-1:0] din_b,
  input logic [W_B-1:0] dout_b
);
  AST_WFIRST_A: assert property (@(posedge clk_a) disable iff (!rst_n) en_a && we_a |=> dout_a == $past(din_a)); // R2
  AST_WFIRST_B: assert property (@(posedge clk_b) disable iff (!rst_n) !SP && en_b && we_b |=> dout_b == $past(din_b)); // R2
  AST_HOLD_A: assert property (@(posedge clk_a) disable iff (!rst_n) !en_a |=> $stable(dout_a)); // R3
  AST_HOLD_B: assert property (@(posedge clk_b) disable iff (!rst_n) !en_b |=> $stable(dout_b)); // R3
  AST_SP_QUIET: assert property (@(posedge clk_b) disable iff (!rst_n) SP |-> dout_b == '0); // R9

  always @(posedge clk_a) if (!rst_n) AST_RST_A: assert (dout_a == '0); // R8
  always @(posedge clk_b) if (!rst_n) AST_RST_B: assert (dout_b == '0); // R8
endmodule

bind mwdp_ram mwdp_ram_chk #(.W_A(WA), .W_B(WB), .SP(SINGLE_PORT)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
  .en_a(en_a), .we_a(we_a), .din_a(din_a), .dout_a(dout_a),
  .en_b(en_b), .we_b(we_b), .din_b(din_b), .dout_b(dout_b)
);

// File: tb/mwdp_ram_test.sv
`timescale 1ns/1ps
module mwdp_ram_test;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #4 clk = ~clk;

  logic        a0_en = 0, a0_we = 0, b0_en = 0, b0_we = 0;
  logic [10:0] a0_ad = '0;
  logic [8:0]  a0_di = '0, a0_do;
  logic [9:0]  b0_ad = '0;
  logic [17:0] b0_di = '0, b0_do;

  logic        a1_en = 0, a1_we = 0, b1_en = 0, b1_we = 0;
  logic [8:0]  a1_ad = '0;
  logic [35:0] a1_di = '0, a1_do;
  logic [9:0]  b1_ad = '0;
  logic [17:0] b1_di = '0, b1_do;

  logic        a2_en = 0, a2_we = 0, b2_en = 0, b2_we = 0;
  logic [9:0]  a2_ad = '0;
  logic [17:0] a2_di = '0, a2_do;
  logic [11:0] b2_ad = '0;
  logic [3:0]  b2_di = '0, b2_do;

  mwdp_ram #(.WIDTH_A(9), .WIDTH_B(18)) uut (
    .clk_a(clk), .rst_n(rst_n), .en_a(a0_en), .we_a(a0_we), .addr_a(a0_ad), .din_a(a0_di), .dout_a(a0_do),
    .clk_b(clk), .en_b(b0_en), .we_b(b0_we), .addr_b(b0_ad), .din_b(b0_di), .dout_b(b0_do));

  mwdp_ram #(.WIDTH_A(36), .WIDTH_B(18), .SINGLE_PORT(1'b1)) u_sp (
    .clk_a(clk), .rst_n(rst_n), .en_a(a1_en), .we_a(a1_we), .addr_a(a1_ad), .din_a(a1_di), .dout_a(a1_do),
    .clk_b(clk), .en_b(b1_en), .we_b(b1_we), .addr_b(b1_ad), .din_b(b1_di), .dout_b(b1_do));

  mwdp_ram #(.WIDTH_A(36), .WIDTH_B(4), .LIMIT_18(1'b1)) u_cap (
    .clk_a(clk), .rst_n(rst_n), .en_a(a2_en), .we_a(a2_we), .addr_a(a2_ad), .din_a(a2_di), .dout_a(a2_do),
    .clk_b(clk), .en_b(b2_en), .we_b(b2_we), .addr_b(b2_ad), .din_b(b2_di), .dout_b(b2_do));

  int checks = 0, errors = 0, collisions = 0;
  bit done = 0;
  logic [35:0] mdl [3][512];

  function automatic int dbits(int w); return (w >= 9) ? (w / 9) * 8 : w; endfunction
  function automatic int pbits(int w); return (w >= 9) ? w / 9 : 0; endfunction

  function automatic logic [35:0] mr(int id, int w, int addr);
    logic [35:0] r = '0;
    int d = dbits(w), p = pbits(w);
    for (int i = 0; i < d; i++) begin int k = addr * d + i; r[i] = mdl[id][k / 32][k % 32]; end
    for (int i = 0; i < p; i++) begin int k = addr * p + i; r[d+i] = mdl[id][k / 4][32 + k % 4]; end
    return r;
  endfunction

  task automatic mw(int id, int w, int addr, logic [35:0] v);
    int d = dbits(w), p = pbits(w);
    for (int i = 0; i < d; i++) begin int k = addr * d + i; mdl[id][k / 32][k % 32] = v[i]; end
    for (int i = 0; i < p; i++) begin int k = addr * p + i; mdl[id][k / 4][32 + k % 4] = v[d+i]; end
  endtask

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    a0_en = 0; a0_we = 0; b0_en = 0; b0_we = 0;
    a1_en = 0; a1_we = 0; b1_en = 0; b1_we = 0;
    a2_en = 0; a2_we = 0; b2_en = 0; b2_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [35:0] exp_a, exp_b;
    int unsigned seed;
    seed = $urandom(32'd5813);
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset uut A", 36'(a0_do), 0);
    chk("R8 reset uut B", 36'(b0_do), 0);
    chk("R8 reset cap A", 36'(a2_do), 0);
    rst_n = 1;

    for (int i = 0; i < 1024; i++) begin
      b0_en = 1; b0_we = 1; b0_ad = 10'(i); b0_di = 18'($urandom);
      a2_en = 1; a2_we = 1; a2_ad = 10'(i); a2_di = 18'($urandom);
      a1_en = (i < 512); a1_we = 1; a1_ad = 9'(i); a1_di = {4'($urandom), 32'($urandom)};
      @(negedge clk);
      mw(0, 18, i, 36'(b0_di));
      mw(2, 18, i, 36'(a2_di));
      if (i < 512) mw(1, 36, i, a1_di);
    end
    idle();

    // R4 R5: two 9-bit words form one 18-bit word
    a0_en = 1; a0_we = 1; a0_ad = 11'd6; a0_di = 9'h1A5; @(negedge clk); mw(0, 9, 6, 36'h1A5);
    chk("R2 write-first A", 36'(a0_do), 36'h1A5);
    a0_ad = 11'd7; a0_di = 9'h0C3; @(negedge clk); mw(0, 9, 7, 36'h0C3);
    idle(); b0_en = 1; b0_ad = 10'd3; @(negedge clk);
    chk("R4 R5 A->B pack", 36'(b0_do), 36'h1C3A5);
    // R7 B->A split
    idle(); b0_en = 1; b0_we = 1; b0_ad = 10'd10; b0_di = 18'h2BEEF; @(negedge clk); mw(0, 18, 10, 36'h2BEEF);
    idle(); a0_en = 1; a0_ad = 11'd20; @(negedge clk);
    chk("R7 B->A low", 36'(a0_do), 36'h0EF);
    a0_ad = 11'd21; @(negedge clk);
    chk("R7 B->A high", 36'(a0_do), 36'h1BE);
    // R3 hold
    idle(); a0_ad = 11'd6; a0_we = 1; a0_di = 9'h000; @(negedge clk);
    chk("R3 hold A", 36'(a0_do), 36'h1BE);
    // R1 top address
    idle(); a0_en = 1; a0_we = 1; a0_ad = 11'd2047; a0_di = 9'h155; @(negedge clk); mw(0, 9, 2047, 36'h155);
    idle(); b0_en = 1; b0_ad = 10'd1023; @(negedge clk);
    chk("R1 top word", 36'(b0_do), mr(0, 18, 1023));
    chk("R1 top byte", 36'({b0_do[17], b0_do[15:8]}), 36'h155);

    // R6 R10 on capped instance
    idle(); a2_en = 1; a2_we = 1; a2_ad = 10'd0; a2_di = 18'h31234; @(negedge clk);
    for (int n = 0; n < 4; n++) begin
      idle(); b2_en = 1; b2_ad = 12'(n); @(negedge clk);
      chk("R6 R4 nibble", 36'(b2_do), 36'(4 - n));
    end
    idle(); b2_en = 1; b2_we = 1; b2_ad = 12'd1; b2_di = 4'hF; @(negedge clk);
    idle(); a2_en = 1; a2_ad = 10'd0; @(negedge clk);
    chk("R6 parity kept", 36'(a2_do), 36'h312F4);
    idle(); a2_en = 1; a2_we = 1; a2_ad = 10'd1023; a2_di = 18'h0ABCD; @(negedge clk);
    idle(); b2_en = 1; b2_ad = 12'd4095; @(negedge clk);
    chk("R10 capped depth", 36'(b2_do), 36'hA);
    b2_ad = 12'd4092; @(negedge clk);
    chk("R10 capped low nibble", 36'(b2_do), 36'hD);

    // R9 single-port instance
    idle(); b1_en = 1; b1_we = 1; b1_ad = 10'd0; b1_di = 18'h3FFFF; @(negedge clk);
    chk("R9 B output quiet", 36'(b1_do), 0);
    idle(); a1_en = 1; a1_ad = 9'd0; @(negedge clk);
    chk("R9 B write ignored", a1_do, mr(1, 36, 0));
    a1_we = 1; a1_ad = 9'd511; a1_di = 36'h987654321; @(negedge clk);
    a1_we = 0; @(negedge clk);
    chk("R9 R5 A 36-bit readback", a1_do, 36'h987654321);

    // random phase on uut
    idle(); a0_en = 1; a0_ad = 11'd0; b0_en = 1; b0_ad = 10'd1; @(negedge clk);
    exp_a = mr(0, 9, 0); exp_b = mr(0, 18, 1);
    chk("R2 read A", 36'(a0_do), exp_a);
    chk("R2 read B", 36'(b0_do), exp_b);
    for (int t = 0; t < 3000; t++) begin
      int ia, ib;
      a0_en = ($urandom % 4) != 0; a0_we = $urandom % 2; a0_di = 9'($urandom);
      a0_ad = (t % 3 == 0) ? 11'($urandom) : 11'($urandom % 64);
      b0_en = ($urandom % 4) != 0; b0_we = $urandom % 2; b0_di = 18'($urandom);
      b0_ad = (t % 3 == 0) ? 10'($urandom) : 10'($urandom % 32);
      ia = int'(a0_ad) * 8; ib = int'(b0_ad) * 16;
      if (a0_en && b0_en && (a0_we || b0_we) && ia < ib + 16 && ib < ia + 8) begin
        b0_en = 0; collisions++;
      end
      if (a0_en) exp_a = a0_we ? 36'(a0_di) : mr(0, 9, int'(a0_ad));
      if (b0_en) exp_b = b0_we ? 36'(b0_di) : mr(0, 18, int'(b0_ad));
      @(negedge clk);
      if (a0_en && a0_we) mw(0, 9, int'(a0_ad), 36'(a0_di));
      if (b0_en && b0_we) mw(0, 18, int'(b0_ad), 36'(b0_di));
      chk("R2 R3 R7 random A", 36'(a0_do), exp_a);
      chk("R2 R3 R7 random B", 36'(b0_do), exp_b);
    end
    $display("note: %0d overlapping cycles dropped", collisions);

    // R8 reset mid-run keeps contents
    idle(); rst_n = 0; #1;
    chk("R8 clear A", 36'(a0_do), 0);
    chk("R8 clear B", 36'(b0_do), 0);
    @(negedge clk); rst_n = 1;
    a0_en = 1; a0_ad = 11'd6; @(negedge clk);
    chk("R8 contents kept", 36'(a0_do), mr(0, 9, 6));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule